// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM whose rows are already open. It accepts one access request at a time: bank, starting column, number of data beats wanted, direction and an auto-precharge wish. It turns each request into a READ or WRITE command on the memory pins, streams write data onto the bus, captures read data once the configured CAS latency has passed, and issues BURST TERMINATE when a burst has to stop before its natural end. Row opening, refresh, initialisation and mode-register setup are handled elsewhere. The static configuration inputs must match what the memory's mode register holds.

Two burst modes are supported. In fixed mode the memory burst length is 1, 2, 4 or 8. In full-page mode a burst runs until it is stopped, and the memory wraps the column from the end of the page back to column 0. A request for fewer beats than the burst would deliver ends in one of two ways. Either the next READ or WRITE is placed in the slot that follows the last wanted beat, or a BURST TERMINATE is placed there. Because of this rule, writes of any length pipeline back to back with no idle cycles. Auto precharge is requested only for bursts that run to their natural length.

Top module: `sdram_burst_seq`

## Requirements
- R1: Memory commands are driven as {cs_n, ras_n, cas_n, we_n} with READ = 4'b0101, WRITE = 4'b0100, BURST TERMINATE = 4'b0110 and NOP = 4'b0111. After reset the pins show NOP and `req_ready` is high.
- R2: A request accepted at a clock edge drives its command in the next cycle. `sd_ba` carries the bank, `sd_addr[8:0]` the column, `sd_addr[10]` the auto-precharge flag, and `sd_addr[9]` and `sd_addr[11]` are 0. Outside READ and WRITE cycles, bank and address are 0.
- R3: The first write beat is on `sd_dq_out` with `sd_dq_oe` high in the WRITE command cycle, and one further beat follows in each following cycle, n beats in all. `wr_take` is high in the cycle before each beat is driven, and `wr_data` is sampled at that edge. After the last beat `sd_dq_oe` drops unless another WRITE starts.
- R4: A new request can be accepted at the edge that ends the last beat of the current burst. This allows single-beat WRITEs in every cycle, to the same bank or to different banks.
- R5: For a READ issued in cycle p, the bus word of cycle p+CL+k (CL from `cfg_cas_lat`, 1 to 3) appears on `rd_data` with `rd_valid` high in cycle p+CL+k+1, for k = 0..n-1.
- R6: A truncated burst is one in full-page mode, or one with n below the fixed length. If no new command is accepted for cycle p+n, BURST TERMINATE is driven in cycle p+n. For a read, this is CL-1 cycles before the last wanted word.
- R7: A truncated write ends with BURST TERMINATE in the cycle after its last beat, with `sd_dq_oe` low in that cycle.
- R8: `sd_addr[10]` is high only if `req_autopre` is set and the burst is not truncated. BURST TERMINATE never follows a command issued with auto precharge.
- R9: The beat count n is `req_beats`, with 0 treated as 1. In fixed mode n is capped at the burst length. In full-page mode n may exceed the 512-column page.
- R10: After a READ issued in cycle p with n beats, a WRITE is not driven before cycle p+n+CL+1. `sd_dq_oe` is never high while read beats are still in flight.
- R11: `done` pulses for one cycle per request. For a write it is cycle p+n. For a read it is the cycle in which the last word leaves on `rd_data`.
- R12: `req_ready` is low while beats of the current burst remain. It is also low for a write request while R10 forbids the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_bl_sel | input | 2 | Fixed burst length as a power of two: 0→1, 1→2, 2→4, 3→8 |
| cfg_full_page | input | 1 | Full-page burst mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Auto precharge wanted |
| req_bank | input | 2 | Target bank |
| req_col | input | 9 | Starting column |
| req_beats | input | 10 | Number of beats wanted |
| wr_data | input | 16 | Next write beat |
| wr_take | output | 1 | `wr_data` is consumed at this edge |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| done | output | 1 | Request finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| sd_dq_out | output | 16 | Data bus, outbound |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 16 | Data bus, inbound |

## Verification
The embedded properties check the following on every cycle:
- an accepted request produces a READ or WRITE command in the next cycle;
- `req_ready` stays low while a multi-beat burst is still running;
- BURST TERMINATE never follows an auto-precharge command;
- a WRITE command always carries its first data beat;
- the data bus is never driven while read words are in flight;
- each done pulse closes a write burst or coincides with the last captured read word.

Only the bench's scenarios can show the rest:
- the exact data values and their cycle alignment for each CAS latency;
- the placement of BURST TERMINATE relative to the last wanted word;
- the beat-count clamping;
- full-page bursts that cross the page end;
- the read-to-write spacing.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int SBS_BEAT_W = 10;  // beat counter width
  localparam int SBS_HOLD_W = SBS_BEAT_W + 2;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BT  = 4'b0110,
    CMD_NOP = 4'b0111
  } sbs_cmd_e;

  // Fixed burst length selected by a two-bit code.
  function automatic logic [3:0] fixed_len(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

  // Beats actually moved for a request.
  function automatic logic [SBS_BEAT_W-1:0] eff_beats(
      input logic [SBS_BEAT_W-1:0] beats,
      input logic full,
      input logic [1:0] sel);
    logic [SBS_BEAT_W-1:0] n;
    logic [SBS_BEAT_W-1:0] lim;
    n   = (beats == '0) ? SBS_BEAT_W'(1) : beats;
    lim = SBS_BEAT_W'(fixed_len(sel));
    if (!full && n > lim) n = lim;
    return n;
  endfunction

  // Burst must be cut short (by a new command or a terminate).
  function automatic logic needs_stop(
      input logic [SBS_BEAT_W-1:0] n,
      input logic full,
      input logic [1:0] sel);
    return full || (n < SBS_BEAT_W'(fixed_len(sel)));
  endfunction

  // Cycles after a READ is accepted before a WRITE may be accepted.
  function automatic logic [SBS_HOLD_W-1:0] rd_wr_gap(
      input logic [SBS_BEAT_W-1:0] n,
      input logic [1:0] cl);
    return SBS_HOLD_W'(n) + SBS_HOLD_W'(cl);
  endfunction

endpackage

// File: rtl/sbs_slot_ctl.sv
module sbs_slot_ctl
  import sbs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_cas_lat,
  input  logic [1:0]            cfg_bl_sel,
  input  logic                  cfg_full_page,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_autopre,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [COL_W-1:0]      req_col,
  input  logic [SBS_BEAT_W-1:0] req_beats,
  output sbs_cmd_e              cmd_q,
  output logic [BANK_W-1:0]     ba_q,
  output logic [ADDR_W-1:0]     addr_q,
  output logic                  wr_beat_n,
  output logic                  wr_last_n,
  output logic                  rd_beat_q,
  output logic                  rd_last_q
);

  logic [SBS_BEAT_W-1:0] n_eff;
  logic                  stop_need;
  logic                  ap_eff;
  logic [SBS_BEAT_W-1:0] left_q;
  logic [SBS_BEAT_W-1:0] burst_n_q;
  logic [SBS_HOLD_W-1:0] hold_q;
  logic                  cur_wr_q;
  logic                  bt_pend_q;
  logic                  last_ap_q;
  logic                  slot_free;
  logic                  dq_free;
  logic                  accept;
  logic                  last_n;
  logic                  rd_beat_n;
  logic [ADDR_W-1:0]     addr_n;

  assign n_eff     = eff_beats(req_beats, cfg_full_page, cfg_bl_sel);
  assign stop_need = needs_stop(n_eff, cfg_full_page, cfg_bl_sel);
  assign ap_eff    = req_autopre && !stop_need;

  assign slot_free = (left_q == '0);
  assign dq_free   = (hold_q == '0);
  assign req_ready = slot_free && (!req_write || dq_free);
  assign accept    = req_valid && req_ready;

  assign wr_beat_n = (accept && req_write)  || (!slot_free && cur_wr_q);
  assign rd_beat_n = (accept && !req_write) || (!slot_free && !cur_wr_q);
  assign last_n    = accept ? (n_eff == SBS_BEAT_W'(1)) : (left_q == SBS_BEAT_W'(1));
  assign wr_last_n = wr_beat_n && last_n;

  always_comb begin
    addr_n                = '0;
    addr_n[COL_W-1:0]     = req_col;
    addr_n[AP_BIT]        = ap_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      burst_n_q <= '0;
      cur_wr_q  <= 1'b0;
      bt_pend_q <= 1'b0;
      last_ap_q <= 1'b0;
    end else if (accept) begin
      cmd_q     <= req_write ? CMD_WR : CMD_RD;
      ba_q      <= req_bank;
      addr_q    <= addr_n;
      left_q    <= n_eff - SBS_BEAT_W'(1);
      burst_n_q <= n_eff;
      cur_wr_q  <= req_write;
      bt_pend_q <= stop_need;
      last_ap_q <= ap_eff;
    end else begin
      ba_q   <= '0;
      addr_q <= '0;
      if (!slot_free) begin
        left_q <= left_q - SBS_BEAT_W'(1);
        cmd_q  <= CMD_NOP;
      end else if (bt_pend_q) begin
        cmd_q     <= CMD_BT;
        bt_pend_q <= 1'b0;
      end else begin
        cmd_q <= CMD_NOP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      rd_beat_q <= 1'b0;
      rd_last_q <= 1'b0;
    end else begin
      if (accept && !req_write) hold_q <= rd_wr_gap(n_eff, cfg_cas_lat);
      else if (!dq_free)        hold_q <= hold_q - SBS_HOLD_W'(1);
      rd_beat_q <= rd_beat_n;
      rd_last_q <= rd_beat_n && last_n;
    end
  end

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_q == CMD_RD || cmd_q == CMD_WR)); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_RD || cmd_q == CMD_WR) && burst_n_q > SBS_BEAT_W'(1)) |-> !req_ready); // R12
  AST_NO_STOP_AFTER_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BT) |-> !last_ap_q); // R8

endmodule

// File: rtl/sbs_wr_path.sv
module sbs_wr_path #(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_beat_n,
  input  logic            wr_last_n,
  input  logic [DQ_W-1:0] wr_data,
  output logic [DQ_W-1:0] sd_dq_out,
  output logic            sd_dq_oe,
  output logic            wr_done
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      last_q    <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      sd_dq_oe <= wr_beat_n;
      if (wr_beat_n) sd_dq_out <= wr_data;
      last_q  <= wr_last_n;
      wr_done <= last_q;
    end
  end

  AST_WDONE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(sd_dq_oe)); // R11

endmodule

// File: rtl/sbs_rd_capture.sv
module sbs_rd_capture #(
  parameter int DQ_W   = 16,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CL_W-1:0] cfg_cas_lat,
  input  logic            rd_beat_q,
  input  logic            rd_last_q,
  input  logic [DQ_W-1:0] sd_dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            rd_done,
  output logic            rd_busy
);

  logic beat_p [MAX_CL];
  logic last_p [MAX_CL];
  logic tap_beat;
  logic tap_last;

  for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          beat_p[0] <= 1'b0;
          last_p[0] <= 1'b0;
        end else begin
          beat_p[0] <= rd_beat_q;
          last_p[0] <= rd_last_q;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          beat_p[i] <= 1'b0;
          last_p[i] <= 1'b0;
        end else begin
          beat_p[i] <= beat_p[i-1];
          last_p[i] <= last_p[i-1];
        end
      end
    end
  end

  // Stage CL-1 is high in the cycle the addressed word sits on the bus.
  always_comb begin
    tap_beat = 1'b0;
    tap_last = 1'b0;
    rd_busy  = rd_beat_q;
    for (int i = 0; i < MAX_CL; i++) begin
      if (cfg_cas_lat == CL_W'(i + 1)) begin
        tap_beat = beat_p[i];
        tap_last = last_p[i];
      end
      if (CL_W'(i) < cfg_cas_lat) rd_busy = rd_busy | beat_p[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      rd_valid <= tap_beat;
      if (tap_beat) rd_data <= sd_dq_in;
      rd_done  <= tap_beat && tap_last;
    end
  end

  AST_RDONE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid); // R11

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int MAX_CL = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_cas_lat,
  input  logic [1:0]            cfg_bl_sel,
  input  logic                  cfg_full_page,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_autopre,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [COL_W-1:0]      req_col,
  input  logic [SBS_BEAT_W-1:0] req_beats,
  input  logic [DQ_W-1:0]       wr_data,
  output logic                  wr_take,
  output logic [DQ_W-1:0]       rd_data,
  output logic                  rd_valid,
  output logic                  done,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]     sd_addr,
  output logic [DQ_W-1:0]       sd_dq_out,
  output logic                  sd_dq_oe,
  input  logic [DQ_W-1:0]       sd_dq_in
);

  sbs_cmd_e cmd_q;
  logic     wr_beat_n;
  logic     wr_last_n;
  logic     rd_beat_q;
  logic     rd_last_q;
  logic     wr_done;
  logic     rd_done;
  logic     rd_busy;

  sbs_slot_ctl #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(10)
  ) u_slot (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(cfg_cas_lat), .cfg_bl_sel(cfg_bl_sel), .cfg_full_page(cfg_full_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_col(req_col),
    .req_beats(req_beats),
    .cmd_q(cmd_q), .ba_q(sd_ba), .addr_q(sd_addr),
    .wr_beat_n(wr_beat_n), .wr_last_n(wr_last_n),
    .rd_beat_q(rd_beat_q), .rd_last_q(rd_last_q)
  );

  sbs_wr_path #(.DQ_W(DQ_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_beat_n(wr_beat_n), .wr_last_n(wr_last_n), .wr_data(wr_data),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .wr_done(wr_done)
  );

  sbs_rd_capture #(.DQ_W(DQ_W), .MAX_CL(MAX_CL), .CL_W(2)) u_rd (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
    .rd_beat_q(rd_beat_q), .rd_last_q(rd_last_q), .sd_dq_in(sd_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done), .rd_busy(rd_busy)
  );

  assign wr_take = wr_beat_n;
  assign done    = wr_done | rd_done;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  AST_WR_DATA_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |-> sd_dq_oe); // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> !rd_busy); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && rd_done)); // R11

endmodule

// File: tb/test_sdram_burst_seq.sv
`timescale 1ns/1ps
module test_sdram_burst_seq;

  localparam bit [3:0] E_RD = 4'b0101, E_WR = 4'b0100, E_BT = 4'b0110, E_NOP = 4'b0111;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_cas_lat = 2'd2;
  logic [1:0]  cfg_bl_sel = 2'd2;
  logic        cfg_full_page = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_autopre = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [8:0]  req_col = '0;
  logic [9:0]  req_beats = '0;
  logic [15:0] wr_data = '0;
  logic        wr_take;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        done;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [15:0] sd_dq_in = '0;

  always #2 clk = ~clk;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(cfg_cas_lat), .cfg_bl_sel(cfg_bl_sel), .cfg_full_page(cfg_full_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_col(req_col), .req_beats(req_beats),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc_idx = 0;
  int nxt_acc = 0;
  int wr_ok = 0;
  bit accepted = 0;

  bit [3:0]  e_cmd  [int];
  bit [1:0]  e_ba   [int];
  bit [11:0] e_addr [int];
  bit        e_oe   [int];
  bit [15:0] e_dq   [int];
  bit        e_take [int];
  bit        e_rdv  [int];
  bit [15:0] e_rdd  [int];
  bit        e_done [int];

  function automatic bit [15:0] wpat(int c);
    return 16'((c * 7) + 16'h1200);
  endfunction
  function automatic bit [15:0] rpat(int c);
    return 16'(c * 13) ^ 16'hC300;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc_idx, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Reference model: decides acceptance, schedules expectations, compares.
  task automatic model_and_compare();
    int c;
    bit rdy;
    c = cyc_idx;
    rdy = (c >= nxt_acc) && (!req_write || c >= wr_ok);
    accepted = 0;
    if (req_valid && rdy) begin
      int n, blen, cl, p;
      bit trunc, ap;
      accepted = 1;
      cl   = int'(cfg_cas_lat);
      blen = 1 << cfg_bl_sel;
      n    = (req_beats == 0) ? 1 : int'(req_beats);            // R9
      if (!cfg_full_page && n > blen) n = blen;                 // R9
      trunc = cfg_full_page || (n < blen);                      // R6
      ap    = req_autopre && !trunc;                            // R8
      p = c + 1;
      e_cmd[p]  = req_write ? E_WR : E_RD;
      e_ba[p]   = req_bank;
      e_addr[p] = {1'b0, ap, 1'b0, req_col};                    // R2
      if (trunc) e_cmd[p + n] = E_BT;                           // R6 R7
      if (req_write) begin
        for (int k = 0; k < n; k++) begin
          e_take[c + k] = 1'b1;
          e_oe[p + k]   = 1'b1;
          e_dq[p + k]   = wpat(c + k);
        end
        e_done[p + n] = 1'b1;
      end else begin
        for (int k = 0; k < n; k++) begin
          e_rdv[p + k + cl + 1] = 1'b1;                         // R5
          e_rdd[p + k + cl + 1] = rpat(p + k + cl);
        end
        e_done[p + n + cl] = 1'b1;
        wr_ok = c + n + cl + 1;                                 // R10
      end
      nxt_acc = c + n;                                          // R4 R12
    end
    begin
      bit [3:0] xc; bit xoe; bit xrdv;
      xc   = e_cmd.exists(c) ? e_cmd[c] : E_NOP;
      xoe  = e_oe.exists(c) ? e_oe[c] : 1'b0;
      xrdv = e_rdv.exists(c) ? e_rdv[c] : 1'b0;
      chk("R6", "cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(xc));
      chk("R2", "ba", 32'(sd_ba), 32'(e_ba.exists(c) ? e_ba[c] : 2'b0));
      chk("R8", "addr", 32'(sd_addr), 32'(e_addr.exists(c) ? e_addr[c] : 12'b0));
      chk("R3", "dq_oe", 32'(sd_dq_oe), 32'(xoe));
      if (xoe) chk("R3", "dq_out", 32'(sd_dq_out), 32'(e_dq[c]));
      chk("R3", "wr_take", 32'(wr_take), 32'(e_take.exists(c) ? e_take[c] : 1'b0));
      chk("R5", "rd_valid", 32'(rd_valid), 32'(xrdv));
      if (xrdv) chk("R5", "rd_data", 32'(rd_data), 32'(e_rdd[c]));
      chk("R11", "done", 32'(done), 32'(e_done.exists(c) ? e_done[c] : 1'b0));
      chk("R12", "req_ready", 32'(req_ready), 32'(rdy));
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    model_and_compare();
    @(posedge clk);
    #1;
    cyc_idx++;
    wr_data  = wpat(cyc_idx);
    sd_dq_in = rpat(cyc_idx);
    if (cyc_idx > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cyc_idx);
      finish_run();
    end
  endtask

  task automatic send(bit w, bit ap, bit [1:0] bank, bit [8:0] col, bit [9:0] beats);
    req_write = w; req_autopre = ap; req_bank = bank; req_col = col; req_beats = beats;
    req_valid = 1'b1;
    do cyc(); while (!accepted);
    req_valid = 1'b0; req_write = 1'b0; req_autopre = 1'b0;
  endtask

  task automatic quiet();
    while (cyc_idx < ((nxt_acc > wr_ok) ? nxt_acc : wr_ok) + 8) cyc();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc_idx = 0;
    wr_data = wpat(0);
    sd_dq_in = rpat(0);
    @(negedge clk);
    // R1: idle command and ready after reset
    chk("R1", "reset cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(E_NOP));
    chk("R1", "reset ready", 32'(req_ready), 32'(1));
    @(posedge clk); #1;

    // Phase A: CL2, fixed length 4
    send(1, 1, 2'd1, 9'h1F0, 10'd4);   // R8 full write keeps A10, R2 fields
    send(1, 1, 2'd2, 9'h010, 10'd2);   // R7 R8 truncated write, A10 forced low
    send(1, 0, 2'd0, 9'h020, 10'd1);   // R4 single-beat writes back to back
    send(1, 0, 2'd3, 9'h021, 10'd1);
    send(1, 0, 2'd0, 9'h022, 10'd1);
    quiet();
    send(0, 0, 2'd1, 9'h040, 10'd4);   // R5 full read
    send(0, 0, 2'd1, 9'h044, 10'd3);   // R6 truncated read, BT at p+n
    send(1, 0, 2'd1, 9'h050, 10'd2);   // R10 write waits for read data
    send(1, 0, 2'd2, 9'h060, 10'd0);   // R9 zero beats means one
    send(1, 0, 2'd2, 9'h061, 10'd9);   // R9 clamp to 4
    quiet();

    // Phase B: CL1, fixed length 8
    cfg_cas_lat = 2'd1; cfg_bl_sel = 2'd3;
    send(0, 1, 2'd0, 9'h100, 10'd8);   // R5 R8
    send(0, 1, 2'd1, 9'h108, 10'd5);   // R6 truncated read cut by next read
    send(0, 0, 2'd1, 9'h110, 10'd2);
    send(1, 0, 2'd3, 9'h120, 10'd3);   // R10 R7
    send(0, 0, 2'd3, 9'h130, 10'd1);   // read right after a write
    quiet();

    // Phase C: CL3, full page
    cfg_cas_lat = 2'd3; cfg_full_page = 1'b1;
    send(0, 1, 2'd2, 9'h180, 10'd600); // R9 crosses page end, R8 A10 low
    send(1, 1, 2'd2, 9'h1FE, 10'd520); // R9 R10
    send(1, 0, 2'd0, 9'h000, 10'd3);   // R4 cuts the previous write
    send(0, 0, 2'd0, 9'h003, 10'd2);   // R6 BT with CL3
    quiet();

    // Phase D: CL3, fixed length 1
    cfg_full_page = 1'b0; cfg_bl_sel = 2'd0;
    send(1, 1, 2'd1, 9'h0AA, 10'd5);   // R9 clamp to 1, R8 A10 kept
    send(1, 1, 2'd2, 9'h0AB, 10'd1);   // R4
    send(0, 0, 2'd3, 9'h0AC, 10'd1);
    send(0, 0, 2'd3, 9'h0AD, 10'd1);   // R5
    quiet();

    finish_run();
  end

endmodule